// File: doc/BRIEF.md
# Oversampled Serial Receive Channel

This block turns an asynchronous serial line into words. An outside baud source supplies a one-cycle enable at sixteen times the bit rate. The block watches the line for a falling edge and confirms it halfway through the start bit. It then samples each data bit at its centre. A word is seven or eight bits long and may arrive least-significant or most-significant bit first. An optional even or odd parity bit follows the data, and then one or two stop bits.

A finished word lands in a holding register and raises a full flag. A one-cycle read strobe from the host empties it. When enabled, the full flag also drives an interrupt request. Parity, overrun and framing problems each set their own sticky flag, and one clear strobe empties all three. A quiet-line flag rises when a full bit time passes after a frame with no new start, and it drops when the next start is confirmed.

The control sequencer has six states:
- `ST_IDLE` (waiting for a low line)
- `ST_START` (confirming the start bit)
- `ST_DATA` (data bits)
- `ST_PARITY`
- `ST_STOP1`
- `ST_STOP2`

Its transitions, each taken on an oversampling enable, are:
- idle→start on a low line.
- start→data when the line is still low at the eighth enable.
- start→idle when it is high there (a glitch).
- data→parity or data→stop1 after the last data bit.
- parity→stop1.
- stop1→stop2 in two-stop mode, or stop1→idle otherwise.
- stop2→idle.

Dropping the receive enable sends any state straight to idle.

Top module: `serial_rx_channel`

## Requirements
- R1: While `rx_en` is 0 no start is accepted, and dropping it during a frame abandons that frame so no word is delivered.
- R2: At the centre sample of the first stop bit the assembled word is written to `rd_data` and `rx_full` becomes 1 on that clock edge.
- R3: A `rd_strobe` pulse clears `rx_full`, unless a frame completes in the same cycle; in that case the strobe counts as the read of the old word, the new word loads, and `rx_full` stays 1.
- R4: With `fmt_msb_first` = 0 the first data bit received lands in `rd_data` bit 0. With `fmt_msb_first` = 1 it lands in the top bit of the word (bit 7 for eight bits, bit 6 for seven bits).
- R5: `rx_irq` is 1 exactly when `rx_full` is 1 and `irq_en` is 1.
- R6: With `fmt_par_en` = 1 a parity bit follows the data. `fmt_par_odd` = 0 demands an even count of ones over data plus parity, and 1 demands an odd count. A mismatch sets `par_err`, which holds until `err_clr`.
- R7: A frame that completes while `rx_full` is 1, with no read strobe in that cycle, sets `ovr_err` and leaves `rd_data` unchanged. `ovr_err` holds until `err_clr`.
- R8: A stop bit sampled low sets `frm_err`, which holds until `err_clr`. In two-stop mode both stop bits are checked.
- R9: `bus_idle` becomes 1 after sixteen oversampling enables in the idle state with no start, and returns to 0 when a start bit is confirmed.
- R10: With `fmt_len8` = 0 only seven data bits are received and `rd_data` bit 7 reads 0 for either bit order.
- R11: A low level that is gone by the eighth oversampling enable after it was first seen is ignored, and no frame follows.
- R12: With `fmt_two_stop` = 1, `rx_full` rises at the first stop bit, one bit time before the second stop bit is checked.
- R13: After reset `rx_full`, `par_err`, `ovr_err` and `frm_err` are 0, `bus_idle` is 1 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receive enable |
| os_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| fmt_len8 | input | 1 | 1 = eight data bits, 0 = seven |
| fmt_msb_first | input | 1 | 1 = most significant bit first |
| fmt_par_en | input | 1 | Parity bit present |
| fmt_par_odd | input | 1 | 1 = odd parity, 0 = even |
| fmt_two_stop | input | 1 | 1 = two stop bits |
| rd_strobe | input | 1 | Host read of the holding register |
| err_clr | input | 1 | Clears the three error flags |
| irq_en | input | 1 | Interrupt enable |
| rd_data | output | DATA_W | Holding register |
| rx_full | output | 1 | Holding register full |
| par_err | output | 1 | Parity error flag |
| ovr_err | output | 1 | Overrun error flag |
| frm_err | output | 1 | Framing error flag |
| bus_idle | output | 1 | No start followed the last frame |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench aims at these weak spots, and each one points to a specific mistake:
- **Full-flag timing in two-stop mode.** A design that waits for the second stop bit shows `rx_full` low during that bit.
- **Seven-bit words sent most-significant first.** Getting the slot arithmetic wrong moves every bit by one and leaks a one into bit 7.
- **Overrun.** A new word that overwrites the held one changes `rd_data`, where it should keep the old word and set the flag.
- **Glitch rejection, aborts and the quiet-line timer.** A short low pulse that starts a frame, a frame that survives a dropped enable, or an off-by-one quiet timer each puts the per-clock reference model out of step with the outputs.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic len8;
        logic msb_first;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } rx_fmt_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '1;
                else        pipe <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '1;
                else        pipe <= {pipe[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
    import srx_pkg::*;
#(
    parameter int OS_RATE = 16,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              os_tick,
    input  logic              line,
    input  rx_fmt_t           fmt_in,
    output logic              start_ok,
    output logic              frame_done,
    output logic [DATA_W-1:0] frame_word,
    output logic              frame_perr,
    output logic              stop1_bad,
    output logic              stop2_bad,
    output logic              line_quiet,
    output logic              word_len8
);

    localparam int CW   = $clog2(OS_RATE);
    localparam int IW   = $clog2(DATA_W + 1);
    localparam int PW   = $clog2(DATA_W);
    localparam int MID  = OS_RATE / 2 - 1;
    localparam int LAST = OS_RATE - 1;

    rx_state_e         state, nxt;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     gap;
    logic [IW-1:0]     bidx;
    logic [IW-1:0]     nbits;
    logic [PW-1:0]     pos;
    logic [DATA_W-1:0] shreg;
    logic              par_q;
    rx_fmt_t           fmt_q;
    logic              at_last, at_mid, last_bit, sample_now;
    logic              data_take, par_take;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    assign at_last  = (cnt == CW'(LAST));
    assign at_mid   = (cnt == CW'(MID));
    assign nbits    = fmt_q.len8 ? IW'(DATA_W) : IW'(DATA_W - 1);
    assign last_bit = (bidx == nbits - 1'b1);

    // Next-state logic
    always_comb begin
        nxt = state;
        if (!enable) begin
            nxt = ST_IDLE;
        end else if (os_tick) begin
            unique case (state)
                ST_IDLE:   if (!line)              nxt = ST_START;
                ST_START:  if (at_mid)             nxt = line ? ST_IDLE : ST_DATA;
                ST_DATA:   if (at_last && last_bit) nxt = fmt_q.par_en ? ST_PARITY : ST_STOP1;
                ST_PARITY: if (at_last)            nxt = ST_STOP1;
                ST_STOP1:  if (at_last)            nxt = fmt_q.two_stop ? ST_STOP2 : ST_IDLE;
                ST_STOP2:  if (at_last)            nxt = ST_IDLE;
                default:                           nxt = ST_IDLE;
            endcase
        end
    end

    // Output / strobe decode
    always_comb begin
        sample_now = enable && os_tick && at_last;
        start_ok   = enable && os_tick && (state == ST_START) && at_mid && !line;
        data_take  = sample_now && (state == ST_DATA);
        par_take   = sample_now && (state == ST_PARITY);
        frame_done = sample_now && (state == ST_STOP1);
        stop1_bad  = frame_done && !line;
        stop2_bad  = sample_now && (state == ST_STOP2) && !line;
        line_quiet = os_tick && (state == ST_IDLE) && (gap == CW'(LAST));
        pos        = fmt_q.msb_first ? PW'(nbits - 1'b1 - bidx) : PW'(bidx);
        frame_word = shreg;
        frame_perr = fmt_q.par_en & (^shreg ^ par_q ^ fmt_q.par_odd);
        word_len8  = fmt_q.len8;
    end

    // Datapath: sample counter, shift register, quiet-line counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            gap   <= '0;
            bidx  <= '0;
            shreg <= '0;
            par_q <= 1'b0;
            fmt_q <= '0;
        end else begin
            if (!enable)
                cnt <= '0;
            else if (os_tick)
                cnt <= (nxt != state || at_last) ? '0 : cnt + 1'b1;

            if (start_ok) begin
                fmt_q <= fmt_in;
                bidx  <= '0;
                shreg <= '0;
            end
            if (data_take) begin
                shreg[pos] <= line;
                bidx       <= bidx + 1'b1;
            end
            if (par_take)
                par_q <= line;

            if (state != ST_IDLE)
                gap <= '0;
            else if (os_tick && gap != CW'(LAST))
                gap <= gap + 1'b1;
        end
    end

endmodule

// File: rtl/srx_result.sv
module srx_result #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] frame_word,
    input  logic              frame_perr,
    input  logic              stop1_bad,
    input  logic              stop2_bad,
    input  logic              start_ok,
    input  logic              line_quiet,
    input  logic              rd_strobe,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              perr,
    output logic              oerr,
    output logic              ferr,
    output logic              idle
);

    logic overrun_now;

    assign overrun_now = frame_done && full && !rd_strobe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            full    <= 1'b0;
            perr    <= 1'b0;
            oerr    <= 1'b0;
            ferr    <= 1'b0;
            idle    <= 1'b1;
        end else begin
            if (frame_done) begin
                full <= 1'b1;
                if (!overrun_now) rd_data <= frame_word;
            end else if (rd_strobe) begin
                full <= 1'b0;
            end

            if (overrun_now)                 oerr <= 1'b1;
            else if (err_clr)                oerr <= 1'b0;

            if (frame_done && frame_perr)    perr <= 1'b1;
            else if (err_clr)                perr <= 1'b0;

            if (stop1_bad || stop2_bad)      ferr <= 1'b1;
            else if (err_clr)                ferr <= 1'b0;

            if (start_ok)                    idle <= 1'b0;
            else if (line_quiet)             idle <= 1'b1;
        end
    end

endmodule

// File: rtl/serial_rx_channel.sv
module serial_rx_channel
    import srx_pkg::*;
#(
    parameter int OS_RATE     = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              fmt_len8,
    input  logic              fmt_msb_first,
    input  logic              fmt_par_en,
    input  logic              fmt_par_odd,
    input  logic              fmt_two_stop,
    input  logic              rd_strobe,
    input  logic              err_clr,
    input  logic              irq_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_full,
    output logic              par_err,
    output logic              ovr_err,
    output logic              frm_err,
    output logic              bus_idle,
    output logic              rx_irq
);

    logic              line_s;
    rx_fmt_t           fmt;
    logic              start_ok, frame_done, frame_perr;
    logic              stop1_bad, stop2_bad, line_quiet, word_len8;
    logic [DATA_W-1:0] frame_word;

    assign fmt = '{len8:      fmt_len8,
                   msb_first: fmt_msb_first,
                   par_en:    fmt_par_en,
                   par_odd:   fmt_par_odd,
                   two_stop:  fmt_two_stop};

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rxd),
        .q     (line_s)
    );

    srx_frame_fsm #(.OS_RATE(OS_RATE), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (rx_en),
        .os_tick    (os_tick),
        .line       (line_s),
        .fmt_in     (fmt),
        .start_ok   (start_ok),
        .frame_done (frame_done),
        .frame_word (frame_word),
        .frame_perr (frame_perr),
        .stop1_bad  (stop1_bad),
        .stop2_bad  (stop2_bad),
        .line_quiet (line_quiet),
        .word_len8  (word_len8)
    );

    srx_result #(.DATA_W(DATA_W)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_word (frame_word),
        .frame_perr (frame_perr),
        .stop1_bad  (stop1_bad),
        .stop2_bad  (stop2_bad),
        .start_ok   (start_ok),
        .line_quiet (line_quiet),
        .rd_strobe  (rd_strobe),
        .err_clr    (err_clr),
        .rd_data    (rd_data),
        .full       (rx_full),
        .perr       (par_err),
        .oerr       (ovr_err),
        .ferr       (frm_err),
        .idle       (bus_idle)
    );

    assign rx_irq = rx_full & irq_en;

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_strobe,
    input logic              err_clr,
    input logic              irq_en,
    input logic              rx_irq,
    input logic              rx_full,
    input logic              ovr_err,
    input logic              frm_err,
    input logic              bus_idle,
    input logic [DATA_W-1:0] rd_data,
    input logic              frame_done,
    input logic              stop2_bad,
    input logic              start_ok,
    input logic              word_len8
);

    // R2
    done_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> rx_full);

    // R3
    read_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !frame_done) |=> !rx_full);

    // R5
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !rx_irq);

    // R5
    irq_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_full);

    // R7
    overrun_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rx_full && !rd_strobe) |=> (ovr_err && $stable(rd_data)));

    // R7
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_err && !err_clr) |=> ovr_err);

    // R8
    second_stop_checked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop2_bad |=> frm_err);

    // R9
    start_clears_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> !bus_idle);

    // R10
    short_word_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !word_len8 && !(rx_full && !rd_strobe)) |=> !rd_data[DATA_W-1]);

endmodule

bind serial_rx_channel srx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_strobe  (rd_strobe),
    .err_clr    (err_clr),
    .irq_en     (irq_en),
    .rx_irq     (rx_irq),
    .rx_full    (rx_full),
    .ovr_err    (ovr_err),
    .frm_err    (frm_err),
    .bus_idle   (bus_idle),
    .rd_data    (rd_data),
    .frame_done (frame_done),
    .stop2_bad  (stop2_bad),
    .start_ok   (start_ok),
    .word_len8  (word_len8)
);

// File: tb/serial_rx_channel_tb.sv
`timescale 1ns/1ps
module serial_rx_channel_tb;

    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0, os_tick = 1'b0, rxd = 1'b1;
    logic fmt_len8 = 1'b1, fmt_msb_first = 1'b0, fmt_par_en = 1'b0;
    logic fmt_par_odd = 1'b0, fmt_two_stop = 1'b0;
    logic rd_strobe = 1'b0, err_clr = 1'b0, irq_en = 1'b0;
    logic [7:0] rd_data;
    logic rx_full, par_err, ovr_err, frm_err, bus_idle, rx_irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    serial_rx_channel u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .os_tick(os_tick), .rxd(rxd),
        .fmt_len8(fmt_len8), .fmt_msb_first(fmt_msb_first), .fmt_par_en(fmt_par_en),
        .fmt_par_odd(fmt_par_odd), .fmt_two_stop(fmt_two_stop),
        .rd_strobe(rd_strobe), .err_clr(err_clr), .irq_en(irq_en),
        .rd_data(rd_data), .rx_full(rx_full), .par_err(par_err), .ovr_err(ovr_err),
        .frm_err(frm_err), .bus_idle(bus_idle), .rx_irq(rx_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Oversampling enable: one cycle in every TICK_DIV
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            os_tick = (div == TICK_DIV - 1);
            div = (div + 1) % TICK_DIV;
        end
    end

    // Behavioural reference model, time measured in enables since the low edge
    int  m_k = -1, m_gap = 0;
    bit  m_s1 = 1, m_s2 = 1;
    bit  [7:0] m_word = 0;
    bit  m_par = 0, l8 = 0, lmsb = 0, lpe = 0, lodd = 0, l2s = 0;
    bit  [7:0] e_data = 0;
    bit  e_full = 0, e_perr = 0, e_oerr = 0, e_ferr = 0, e_idle = 1;

    always @(posedge clk) begin : model
        bit ln, done, bad1, bad2, sok, quiet, pbad;
        int nb, pb, j;
        if (!rst_n) begin
            m_k = -1; m_gap = 0; m_s1 = 1; m_s2 = 1; m_word = 0; m_par = 0;
            l8 = 0; lmsb = 0; lpe = 0; lodd = 0; l2s = 0;
            e_data = 0; e_full = 0; e_perr = 0; e_oerr = 0; e_ferr = 0; e_idle = 1;
        end else begin
            ln = m_s2; done = 0; bad1 = 0; bad2 = 0; sok = 0; pbad = 0;
            quiet = os_tick && (m_k < 0) && (m_gap == 15);
            if (m_k >= 0) m_gap = 0;
            else if (os_tick && m_gap < 15) m_gap++;

            if (m_k < 0) begin
                if (rx_en && os_tick && !ln) m_k = 0;
            end else if (!rx_en) begin
                m_k = -1;
            end else if (os_tick) begin
                m_k++;
                nb = l8 ? 8 : 7;
                pb = lpe ? 1 : 0;
                if (m_k == 8) begin
                    if (ln) m_k = -1;
                    else begin
                        sok = 1; m_word = 0;
                        l8 = fmt_len8; lmsb = fmt_msb_first; lpe = fmt_par_en;
                        lodd = fmt_par_odd; l2s = fmt_two_stop;
                    end
                end else if (m_k >= 24 && (m_k - 24) % 16 == 0) begin
                    j = (m_k - 24) / 16;
                    if (j < nb) m_word[lmsb ? nb - 1 - j : j] = ln;
                    else if (pb == 1 && j == nb) m_par = ln;
                    else if (j == nb + pb) begin
                        done = 1; bad1 = !ln;
                        pbad = lpe && ((^m_word) ^ m_par ^ lodd);
                        if (!l2s) m_k = -1;
                    end else begin
                        bad2 = !ln; m_k = -1;
                    end
                end
            end

            if (err_clr) begin e_perr = 0; e_oerr = 0; e_ferr = 0; end
            if (done) begin
                if (e_full && !rd_strobe) e_oerr = 1;
                else e_data = m_word;
                e_full = 1;
                if (pbad) e_perr = 1;
                if (bad1) e_ferr = 1;
            end else if (rd_strobe) e_full = 0;
            if (bad2) e_ferr = 1;
            if (sok) e_idle = 0;
            else if (quiet) e_idle = 1;

            m_s2 = m_s1; m_s1 = rxd;
        end
    end

    // Compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2 per-clock data", rd_data, e_data);
            chk("R3 per-clock full", rx_full, e_full);
            chk("R6 per-clock parity flag", par_err, e_perr);
            chk("R7 per-clock overrun flag", ovr_err, e_oerr);
            chk("R8 per-clock framing flag", frm_err, e_ferr);
            chk("R9 per-clock idle flag", bus_idle, e_idle);
            chk("R5 per-clock irq", rx_irq, e_full & irq_en);
        end
    end

    task automatic drive_bit(input bit v);
        rxd = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic quiet_bits(input int n);
        repeat (n) drive_bit(1'b1);
    endtask

    task automatic send_head(input bit [7:0] w, input bit bad_par);
        int nb = fmt_len8 ? 8 : 7;
        bit p;
        drive_bit(1'b0);
        for (int j = 0; j < nb; j++) drive_bit(fmt_msb_first ? w[nb - 1 - j] : w[j]);
        p = (^(w & (fmt_len8 ? 8'hFF : 8'h7F))) ^ fmt_par_odd ^ bad_par;
        if (fmt_par_en) drive_bit(p);
    endtask

    task automatic send_frame(input bit [7:0] w, input bit bad_par, input bit s1, input bit s2);
        send_head(w, bad_par);
        drive_bit(s1);
        if (fmt_two_stop) drive_bit(s2);
        quiet_bits(2);
    endtask

    task automatic read_word();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_errs();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13: reset state
        chk("R13 full after reset", rx_full, 0);
        chk("R13 errors after reset", {par_err, ovr_err, frm_err}, 0);
        chk("R13 idle after reset", bus_idle, 1);
        chk("R13 data after reset", rd_data, 0);

        // R1: disabled receiver ignores a frame
        send_frame(8'h96, 0, 1, 1);
        chk("R1 no word while disabled", rx_full, 0);
        rx_en = 1'b1;
        quiet_bits(1);

        // R2, R4: eight bits, LSB first
        send_frame(8'hA5, 0, 1, 1);
        chk("R2 full after frame", rx_full, 1);
        chk("R4 lsb-first word", rd_data, 8'hA5);
        irq_en = 1'b1; @(negedge clk);
        chk("R5 irq with enable", rx_irq, 1);
        irq_en = 1'b0; @(negedge clk);
        chk("R5 irq masked", rx_irq, 0);
        read_word();
        chk("R3 read clears full", rx_full, 0);

        // R4: eight bits, MSB first
        fmt_msb_first = 1'b1;
        send_frame(8'h1D, 0, 1, 1);
        chk("R4 msb-first word", rd_data, 8'h1D);
        read_word();

        // R10: seven bits, both orders
        fmt_len8 = 1'b0;
        send_frame(8'hB3, 0, 1, 1);
        chk("R10 seven-bit msb-first word", rd_data, 8'h33);
        read_word();
        fmt_msb_first = 1'b0;
        send_frame(8'hDA, 0, 1, 1);
        chk("R10 seven-bit lsb-first word", rd_data, 8'h5A);
        read_word();
        fmt_len8 = 1'b1;

        // R6: parity
        fmt_par_en = 1'b1;
        send_frame(8'h37, 0, 1, 1);
        chk("R6 good even parity", par_err, 0);
        chk("R6 word with parity", rd_data, 8'h37);
        read_word();
        send_frame(8'h37, 1, 1, 1);
        chk("R6 bad even parity", par_err, 1);
        read_word();
        clear_errs();
        chk("R6 clear strobe", par_err, 0);
        fmt_par_odd = 1'b1;
        send_frame(8'h37, 0, 1, 1);
        chk("R6 good odd parity", par_err, 0);
        read_word();
        send_frame(8'h0F, 1, 1, 1);
        chk("R6 bad odd parity", par_err, 1);
        read_word();
        clear_errs();
        fmt_par_en = 1'b0; fmt_par_odd = 1'b0;

        // R7: overrun keeps the old word
        send_frame(8'h11, 0, 1, 1);
        send_frame(8'h22, 0, 1, 1);
        chk("R7 overrun flag", ovr_err, 1);
        chk("R7 old word kept", rd_data, 8'h11);
        chk("R7 full stays", rx_full, 1);
        read_word();
        chk("R7 flag survives read", ovr_err, 1);
        clear_errs();
        chk("R7 clear strobe", ovr_err, 0);

        // R8: low first stop bit
        send_frame(8'h5C, 0, 0, 1);
        chk("R8 framing on stop bit", frm_err, 1);
        chk("R8 word still delivered", rd_data, 8'h5C);
        read_word();
        clear_errs();

        // R12, R8: two stop bits, full early, second stop low
        fmt_two_stop = 1'b1;
        send_head(8'hC6, 0);
        drive_bit(1'b1);
        rxd = 1'b0;
        repeat (10) @(negedge clk);
        chk("R12 full before second stop", rx_full, 1);
        chk("R12 no framing yet", frm_err, 0);
        chk("R9 idle low inside frame", bus_idle, 0);
        repeat (BIT_CLKS - 10) @(negedge clk);
        chk("R8 second stop checked", frm_err, 1);
        quiet_bits(2);
        read_word();
        clear_errs();
        send_frame(8'h3A, 0, 1, 1);
        chk("R12 good two-stop frame", frm_err, 0);
        chk("R12 two-stop word", rd_data, 8'h3A);
        read_word();
        fmt_two_stop = 1'b0;

        // R9: idle after a quiet bit time
        quiet_bits(1);
        chk("R9 idle after quiet line", bus_idle, 1);

        // R11: short low glitch is ignored
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        chk("R11 glitch gives no word", rx_full, 0);
        chk("R11 glitch keeps idle", bus_idle, 1);

        // R1: dropping enable mid-frame abandons it
        drive_bit(1'b0);
        drive_bit(1'b1);
        drive_bit(1'b0);
        rx_en = 1'b0;
        repeat (6) drive_bit(1'b1);
        drive_bit(1'b1);
        quiet_bits(2);
        rx_en = 1'b1;
        quiet_bits(1);
        chk("R1 aborted frame gives no word", rx_full, 0);

        // R3: read strobe in the completing cycle is a read of the old word
        send_frame(8'h44, 0, 1, 1);
        chk("R3 first word held", rd_data, 8'h44);
        fork
            send_frame(8'h55, 0, 1, 1);
            begin
                rd_strobe = 1'b1;
                repeat (10 * BIT_CLKS) @(negedge clk);
                rd_strobe = 1'b0;
            end
        join
        chk("R3 no overrun with strobe held", ovr_err, 0);

        finish_run();
    end

endmodule